// File: doc/BRIEF.md
# Zoned / Packed Decimal Stream Converter

This block converts signed decimal numbers between two byte layouts in either direction. In the zoned layout each digit takes a whole byte: the digit value sits in the low nibble and a zone nibble sits in the high nibble. In the packed layout two digits share a byte and a sign nibble closes the number. A mode input picks the direction. A style input picks the zone used for zoned digits: F, or the character-style 3.

Bytes enter one per cycle on a valid/ready stream, most significant first. The digit count (1 to `MAX_DIGITS`), the mode and the style are sampled together with the first byte of each number. Bytes leave on a second valid/ready stream that marks the final byte of each number. When packing, the sign comes from the zone of the last zoned byte and moves into the low nibble of the last packed byte. When unpacking, the packed sign moves back into the zone of the last zoned byte. An even digit count packs with one leading zero nibble, so the packed result is right aligned. Bad digit nibbles and bad packed signs raise error flags. These flags are presented with the final output byte.

Top module: `zoned_packed_conv`

## Requirements
- R1: Pack mode (mode=0) takes d zoned bytes and emits d/2+1 bytes (integer division). The output is the nibble sequence [0 if d is even], digit1..digitd, sign, taken in pairs with the earlier nibble in bits 7:4. Each digit is the low nibble of its zoned byte. The zone of every byte except the last has no effect on the output.
- R2: In pack mode the output sign nibble is D when the zone of the last zoned byte is D. For any other zone it is C.
- R3: Unpack mode (mode=1) takes d/2+1 packed bytes and emits d bytes. Each output byte is {zone, digit}, with zone F when style=0 and 3 when style=1. The leading pad nibble of an even count is dropped.
- R4: In unpack mode the last output byte carries zone D when the packed sign nibble is D. For any other sign nibble it carries the style zone.
- R5: A digit nibble of A..F sets digit_error. In pack mode every low nibble is checked. In unpack mode every nibble except the pad and the sign is checked. The flag is high while the final output byte is presented, and the bad nibble is still passed through. Flags stay stable while that byte is stalled.
- R6: In unpack mode a packed sign nibble of 0..9 sets sign_error, presented with the final output byte. Pack mode never sets sign_error.
- R7: Both flags clear once the final output byte is accepted. A number free of errors shows both flags low on its final byte.
- R8: out_last is high on exactly the final byte of each number.
- R9: While out_valid is high and out_ready is low, out_data and out_last hold and in_ready is low. No byte is lost or repeated under backpressure on either side.
- R10: Mode, style and digit count are taken from the cycle the first byte is accepted. Changes to them later in the same number have no effect.
- R11: After reset out_valid is low, in_ready is high and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = zoned to packed, 1 = packed to zoned |
| zone_style | input | 1 | 0 = zone F, 1 = zone 3 |
| digit_count | input | CNT_W | Digits in the number, 1..MAX_DIGITS (0 taken as 1) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte, most significant first |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the number |
| digit_error | output | 1 | Non-decimal digit nibble seen in this number |
| sign_error | output | 1 | Packed sign nibble in 0..9 seen in this number |

## Verification
Numbers of length 1, 2, odd, even and the maximum are converted in both directions. Odd and even lengths show whether the pad nibble is inserted and dropped correctly, and length 1 shows a first byte that is also the last. Sign nibbles C, D, F and B are unpacked, and positive and negative numbers are packed with both styles and with junk zones on the inner bytes. This separates the sign mapping from the zone that is passed through. Throttled valid and ready patterns on both streams, and mode or count changes after the first byte, show that the streams lose no bytes and that framing is sampled once per number.

// File: rtl/zdc_pkg.sv
package zdc_pkg;
   localparam logic [3:0] ZONE_F   = 4'hF;
   localparam logic [3:0] ZONE_CHR = 4'h3;
   localparam logic [3:0] SGN_POS  = 4'hC;
   localparam logic [3:0] SGN_NEG  = 4'hD;

   typedef enum logic {
      DIR_PACK   = 1'b0,
      DIR_UNPACK = 1'b1
   } dir_e;

   function automatic logic nib_bad(input logic [3:0] n);
      return n > 4'd9;
   endfunction

   function automatic logic [3:0] style_zone(input logic style);
      return style ? ZONE_CHR : ZONE_F;
   endfunction
endpackage

// File: rtl/zdc_frame_ctl.sv
module zdc_frame_ctl #(
   parameter int MAX_DIGITS = 31,
   parameter int CNT_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             mode_in,
   input  logic             style_in,
   input  logic [CNT_W-1:0] count_in,
   output logic             mode_o,
   output logic             style_o,
   output logic             first_o,
   output logic             last_o,
   output logic             even_o
);
   logic             busy;
   logic             mode_q, style_q;
   logic [CNT_W-1:0] idx, cnt_q;
   logic [CNT_W-1:0] cnt_raw, cnt_eff, total, idx_eff;

   always_comb begin
      cnt_raw = busy ? cnt_q : count_in;
      if (cnt_raw == '0)
         cnt_eff = CNT_W'(1);
      else if (cnt_raw > CNT_W'(MAX_DIGITS))
         cnt_eff = CNT_W'(MAX_DIGITS);
      else
         cnt_eff = cnt_raw;
      mode_o  = busy ? mode_q : mode_in;
      style_o = busy ? style_q : style_in;
      total   = (mode_o == zdc_pkg::DIR_UNPACK) ? (cnt_eff >> 1) + CNT_W'(1) : cnt_eff;
      idx_eff = busy ? idx : '0;
      first_o = !busy;
      last_o  = (idx_eff == total - CNT_W'(1));
      even_o  = !cnt_eff[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         cnt_q   <= '0;
         mode_q  <= 1'b0;
         style_q <= 1'b0;
      end else if (accept) begin
         if (!busy) begin
            cnt_q   <= cnt_eff;
            mode_q  <= mode_in;
            style_q <= style_in;
         end
         busy <= !last_o;
         idx  <= last_o ? '0 : idx_eff + CNT_W'(1);
      end
   end
endmodule

// File: rtl/zdc_pack_lane.sv
module zdc_pack_lane (
   input  logic [7:0] in_byte,
   input  logic       first,
   input  logic       last,
   input  logic       even,
   input  logic       held_v,
   input  logic [3:0] held_nib,
   output logic       emit,
   output logic [7:0] out_byte,
   output logic       held_v_nxt,
   output logic [3:0] held_nib_nxt,
   output logic       dig_err
);
   import zdc_pkg::*;

   logic       hv_eff;
   logic [3:0] hn_eff, digit, sgn;

   always_comb begin
      // the pad nibble of an even count acts as an already held nibble
      hv_eff       = first ? even : held_v;
      hn_eff       = first ? 4'h0 : held_nib;
      digit        = in_byte[3:0];
      sgn          = (in_byte[7:4] == SGN_NEG) ? SGN_NEG : SGN_POS;
      dig_err      = nib_bad(digit);
      emit         = 1'b0;
      out_byte     = 8'h00;
      held_v_nxt   = 1'b0;
      held_nib_nxt = hn_eff;
      if (last) begin
         emit     = 1'b1;
         out_byte = {digit, sgn};
      end else if (hv_eff) begin
         emit     = 1'b1;
         out_byte = {hn_eff, digit};
      end else begin
         held_v_nxt   = 1'b1;
         held_nib_nxt = digit;
      end
   end
endmodule

// File: rtl/zdc_unpack_lane.sv
module zdc_unpack_lane (
   input  logic [7:0] in_byte,
   input  logic       first,
   input  logic       last,
   input  logic       even,
   input  logic       style,
   output logic [7:0] byte0,
   output logic [7:0] byte1,
   output logic       two,
   output logic       dig_err,
   output logic       sgn_err
);
   import zdc_pkg::*;

   logic [1:0] bad;
   logic [3:0] zone, hi, lo;

   for (genvar g = 0; g < 2; g++) begin : g_nib
      assign bad[g] = nib_bad(in_byte[4*g+3 -: 4]);
   end

   always_comb begin
      zone    = style_zone(style);
      hi      = in_byte[7:4];
      lo      = in_byte[3:0];
      byte0   = {zone, hi};
      byte1   = {zone, lo};
      two     = 1'b0;
      dig_err = 1'b0;
      sgn_err = 1'b0;
      if (last) begin
         byte0   = {(lo == SGN_NEG) ? SGN_NEG : zone, hi};
         dig_err = bad[1];
         sgn_err = !bad[0];
      end else if (first && even) begin
         byte0   = {zone, lo};
         dig_err = bad[0];
      end else begin
         two     = 1'b1;
         dig_err = |bad;
      end
   end
endmodule

// File: rtl/zoned_packed_conv.sv
module zoned_packed_conv #(
   parameter  int MAX_DIGITS = 31,
   localparam int CNT_W      = $clog2(MAX_DIGITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode,
   input  logic             zone_style,
   input  logic [CNT_W-1:0] digit_count,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_last,
   output logic             digit_error,
   output logic             sign_error
);
   import zdc_pkg::*;

   if (MAX_DIGITS < 1 || MAX_DIGITS > 255) begin : g_bad_digits
      $error("MAX_DIGITS must lie in 1..255");
   end

   logic       acc, f_mode, f_style, f_first, f_last, f_even;
   logic       held_v, p_emit, p_hv_nxt, p_derr;
   logic [3:0] held_nib, p_hn_nxt;
   logic [7:0] p_byte, u_b0, u_b1;
   logic       u_two, u_derr, u_serr;
   logic       pend_v;
   logic [7:0] pend_data;
   logic       new_derr, new_serr, err_clr;

   assign in_ready = !pend_v && (!out_valid || out_ready);
   assign acc      = in_valid && in_ready;
   assign err_clr  = out_valid && out_ready && out_last;

   zdc_frame_ctl #(.MAX_DIGITS(MAX_DIGITS), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .accept(acc),
      .mode_in(mode), .style_in(zone_style), .count_in(digit_count),
      .mode_o(f_mode), .style_o(f_style), .first_o(f_first),
      .last_o(f_last), .even_o(f_even)
   );

   zdc_pack_lane u_pack (
      .in_byte(in_data), .first(f_first), .last(f_last), .even(f_even),
      .held_v(held_v), .held_nib(held_nib), .emit(p_emit), .out_byte(p_byte),
      .held_v_nxt(p_hv_nxt), .held_nib_nxt(p_hn_nxt), .dig_err(p_derr)
   );

   zdc_unpack_lane u_unpack (
      .in_byte(in_data), .first(f_first), .last(f_last), .even(f_even),
      .style(f_style), .byte0(u_b0), .byte1(u_b1), .two(u_two),
      .dig_err(u_derr), .sgn_err(u_serr)
   );

   always_comb begin
      new_derr = acc && ((f_mode == DIR_UNPACK) ? u_derr : p_derr);
      new_serr = acc && (f_mode == DIR_UNPACK) && u_serr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= 8'h00;
         out_last    <= 1'b0;
         pend_v      <= 1'b0;
         pend_data   <= 8'h00;
         held_v      <= 1'b0;
         held_nib    <= 4'h0;
         digit_error <= 1'b0;
         sign_error  <= 1'b0;
      end else begin
         if (acc) begin
            if (f_mode == DIR_UNPACK) begin
               out_valid <= 1'b1;
               out_data  <= u_b0;
               out_last  <= f_last;
               pend_v    <= u_two;
               pend_data <= u_b1;
            end else begin
               held_v   <= p_hv_nxt;
               held_nib <= p_hn_nxt;
               if (p_emit) begin
                  out_valid <= 1'b1;
                  out_data  <= p_byte;
                  out_last  <= f_last;
               end else begin
                  out_valid <= 1'b0;
                  out_last  <= 1'b0;
               end
            end
         end else if (out_valid && out_ready) begin
            if (pend_v) begin
               out_data <= pend_data;
               out_last <= 1'b0;
               pend_v   <= 1'b0;
            end else begin
               out_valid <= 1'b0;
               out_last  <= 1'b0;
            end
         end
         digit_error <= (err_clr ? 1'b0 : digit_error) | new_derr;
         sign_error  <= (err_clr ? 1'b0 : sign_error) | new_serr;
      end
   end
endmodule

// File: rtl/zdc_checker.sv
module zdc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_last,
   input logic       digit_error,
   input logic       sign_error
);
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   p_in_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> $stable(digit_error) && $stable(sign_error));

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last && !(in_valid && in_ready)
      |=> !digit_error && !sign_error);

   p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && in_ready && !digit_error && !sign_error);

   p_last_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |->
         (out_data[3:0] == 4'hC) || (out_data[3:0] == 4'hD) ||
         (out_data[7:4] == 4'hF) || (out_data[7:4] == 4'h3) || (out_data[7:4] == 4'hD));
endmodule

bind zoned_packed_conv zdc_checker u_zdc_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_last(out_last), .digit_error(digit_error), .sign_error(sign_error)
);

// File: tb/tb_zoned_packed_conv.sv
module tb_zoned_packed_conv;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode = 1'b0, zone_style = 1'b0;
   logic [4:0] digit_count = 5'd1;
   logic       in_valid = 1'b0, out_ready = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready, out_valid, out_last, digit_error, sign_error;
   logic [7:0] out_data;

   int checks = 0, errors = 0;
   logic [7:0] ibuf [0:31];
   logic [7:0] ebuf [0:31];
   logic [7:0] obuf [0:31];
   logic [3:0] nib  [0:33];

   always #2 clk = ~clk;

   zoned_packed_conv dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .zone_style(zone_style),
      .digit_count(digit_count), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .digit_error(digit_error),
      .sign_error(sign_error)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] dg(input int i, input int seed);
      return 4'((i * 7 + seed) % 10);
   endfunction

   // zoned input, packed expectation
   task automatic build_pack(input int d, input int seed, input bit neg, input bit st,
                             input bit junk, input int bad_pos);
      logic [3:0] z = st ? 4'h3 : 4'hF;
      int k = 0;
      for (int i = 0; i < d; i++) begin
         logic [3:0] v = (i == bad_pos) ? 4'hB : dg(i, seed);
         logic [3:0] zz = junk ? 4'(4'h5 + i % 7) : z;
         if (i == d - 1) zz = neg ? 4'hD : (junk ? 4'h7 : z);
         ibuf[i] = {zz, v};
      end
      if (d % 2 == 0) begin nib[k] = 4'h0; k++; end
      for (int i = 0; i < d; i++) begin nib[k] = ibuf[i][3:0]; k++; end
      nib[k] = neg ? 4'hD : 4'hC;
      for (int j = 0; j < d / 2 + 1; j++) ebuf[j] = {nib[2*j], nib[2*j+1]};
   endtask

   // packed input, zoned expectation
   task automatic build_unpack(input int d, input int seed, input logic [3:0] sn,
                               input bit st, input int bad_pos);
      logic [3:0] z = st ? 4'h3 : 4'hF;
      int k = 0;
      if (d % 2 == 0) begin nib[k] = 4'h0; k++; end
      for (int i = 0; i < d; i++) begin
         nib[k] = (i == bad_pos) ? 4'hE : dg(i, seed);
         ebuf[i] = {z, nib[k]};
         k++;
      end
      nib[k] = sn;
      ebuf[d-1][7:4] = (sn == 4'hD) ? 4'hD : z;
      for (int j = 0; j < d / 2 + 1; j++) ibuf[j] = {nib[2*j], nib[2*j+1]};
   endtask

   task automatic run_msg(input bit m, input bit st, input int d, input int nin,
                          input bit stall, input bit scramble,
                          output int nout, output bit derr, output bit serr);
      int ip = 0, cyc = 0;
      bit got_last = 0, prev_hold = 0;
      logic [7:0] prev_d = 8'h00;
      nout = 0; derr = 0; serr = 0;
      while (!got_last && cyc < 800) begin
         @(negedge clk);
         out_ready   = stall ? (cyc % 3 != 0) : 1'b1;
         in_valid    = (ip < nin) && (stall ? (cyc % 4 != 1) : 1'b1);
         in_data     = (ip < nin) ? ibuf[ip] : 8'h00;
         mode        = (scramble && ip > 0) ? ~m : m;
         zone_style  = (scramble && ip > 0) ? ~st : st;
         digit_count = (scramble && ip > 0) ? 5'(d ^ 5'h13) : 5'(d);
         #1;
         if (prev_hold) chk(out_data == prev_d, "R9 hold", out_data, prev_d);
         if (out_valid && !out_ready) chk(!in_ready, "R9 in_ready", in_ready, 0);
         prev_hold = out_valid && !out_ready;
         prev_d    = out_data;
         if (out_valid && out_ready) begin
            if (nout < 32) obuf[nout] = out_data;
            if (out_last) begin got_last = 1; derr = digit_error; serr = sign_error; end
            nout++;
         end
         if (in_valid && in_ready) ip++;
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      chk(got_last, "R8 timeout", got_last, 1);
      chk(ip == nin, "R9 inputs taken", ip, nin);
      #1;
      chk(!digit_error && !sign_error, "R7 cleared", {digit_error, sign_error}, 0);
   endtask

   task automatic compare(input string req, input int nexp, input int nout,
                          input bit derr, input bit serr, input bit ed, input bit es);
      chk(nout == nexp, {req, " R8 count"}, nout, nexp);
      for (int j = 0; j < nexp && j < nout && j < 32; j++)
         chk(obuf[j] === ebuf[j], req, obuf[j], ebuf[j]);
      chk(derr == ed, {req, " R5 digit_error"}, derr, ed);
      chk(serr == es, {req, " R6 sign_error"}, serr, es);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!out_valid, "R11 out_valid", out_valid, 0);
      chk(in_ready, "R11 in_ready", in_ready, 1);
      chk(!digit_error && !sign_error, "R11 flags", {digit_error, sign_error}, 0);
   endtask

   task automatic t_pack(input int d, input int seed, input bit neg, input bit st,
                         input bit junk, input bit stall, input int bad_pos, input bit scr);
      int n; bit de, se;
      build_pack(d, seed, neg, st, junk, bad_pos);
      run_msg(1'b0, st, d, d, stall, scr, n, de, se);
      compare(neg ? "R1 R2 pack neg" : "R1 R2 pack pos", d / 2 + 1, n, de, se,
              bad_pos >= 0, 1'b0);
   endtask

   task automatic t_unpack(input int d, input int seed, input logic [3:0] sn, input bit st,
                           input bit stall, input int bad_pos, input bit scr);
      int n; bit de, se;
      build_unpack(d, seed, sn, st, bad_pos);
      run_msg(1'b1, st, d, d / 2 + 1, stall, scr, n, de, se);
      compare("R3 R4 unpack", d, n, de, se, bad_pos >= 0, sn <= 4'd9);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_pack(1, 3, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
      t_pack(2, 4, 1'b1, 1'b0, 1'b0, 1'b0, -1, 1'b0);
      t_pack(7, 1, 1'b1, 1'b1, 1'b0, 1'b1, -1, 1'b0);
      t_pack(8, 2, 1'b0, 1'b1, 1'b1, 1'b1, -1, 1'b0);   // R1 inner zones ignored, R2 zone 7 -> C
      t_pack(31, 5, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1'b0);
      t_pack(6, 0, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0);    // R5 digit error in pack
      t_pack(4, 9, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);   // R7 clean after error
      t_unpack(1, 6, 4'hC, 1'b0, 1'b0, -1, 1'b0);
      t_unpack(2, 7, 4'hD, 1'b1, 1'b0, -1, 1'b0);
      t_unpack(5, 8, 4'hF, 1'b1, 1'b1, -1, 1'b0);
      t_unpack(6, 2, 4'hB, 1'b0, 1'b1, -1, 1'b0);
      t_unpack(31, 3, 4'hD, 1'b0, 1'b1, -1, 1'b0);
      t_unpack(5, 4, 4'h5, 1'b0, 1'b0, -1, 1'b0);       // R6 sign error
      t_unpack(6, 1, 4'hC, 1'b1, 1'b0, 3, 1'b0);        // R5 digit error in unpack
      t_unpack(3, 5, 4'hC, 1'b0, 1'b0, -1, 1'b0);       // R7 clean after error
      t_pack(9, 6, 1'b1, 1'b0, 1'b0, 1'b1, -1, 1'b1);   // R10 controls changed mid-number
      t_unpack(9, 7, 4'hC, 1'b1, 1'b1, -1, 1'b1);       // R10
      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule